// File: doc/BRIEF.md
# Dual-Rail Self-Timed Pipeline

This block is a chain of identical pipeline stages that move dual-rail coded words without a shared timing strobe. Each stage passes its input through a fixed dual-rail function, a bitwise inversion that swaps the two rails of every bit. It then captures the result in a register made of Muller C-elements. Completion detectors built as trees of C-elements report to the previous stage when the current phase has fully arrived. Words alternate with spacers. A stage register may take a new working word only while the following stage reports spacer. It may fall back to spacer only while the following stage reports a completed word.

The edge of the block uses four-phase handshakes. The producer presents a complete word and holds it until `in_ack` rises. It then presents the spacer and holds it until `in_ack` falls. The consumer sees a complete word on the output rails and raises `out_ack`. The block then returns the output to spacer, and the consumer lowers `out_ack`. Every C-element is modelled as a unit-delay element that re-evaluates on each `clk` tick. `clk` is therefore a simulation time step and has no role in the protocol. Any tick rate gives the same ordering of events.

Top module: `selftimed_pipe`

## Requirements
- R1: Each data bit is a rail pair {t,f}. {0,0} is the spacer, {0,1} is logic 0, {1,0} is logic 1, and {1,1} is illegal. {1,1} never appears on the output rails or in any stage register.
- R2: Every word delivered on the output equals the accepted input word inverted once per stage. With an odd STAGES count the output is the bitwise complement, and with an even count it is the input value.
- R3: Words leave in the order they were accepted, with none lost and none duplicated.
- R4: While rst_n is low, every output rail and in_ack are 0, whatever the input rails carry.
- R5: in_ack rises only while the input carries a complete word, and it falls only while the input is all spacer.
- R6: While out_ack is low, a complete word on the output stays unchanged.
- R7: While out_ack is low, no output rail falls. While out_ack is high, no output rail rises, so a spacer on the output stays spacer until out_ack falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Unit-delay time step for the C-element models |
| rst_n | input | 1 | Asynchronous active-low reset that forces every stage to spacer |
| in_t | input | W | True rails of the input word |
| in_f | input | W | False rails of the input word |
| in_ack | output | 1 | Input acknowledge: high once a word is taken, low once the spacer is taken |
| out_t | output | W | True rails of the output word |
| out_f | output | W | False rails of the output word |
| out_ack | input | 1 | Output acknowledge from the consumer |

## Verification
The bench uses a five-stage chain, so the inversion shows at the output. It sends all-zero, all-one and alternating words, plus single set bits at either edge, and then random words. Producer and consumer delays are random, so words pile up behind a stalled consumer and the spacer and working waves overlap. A register enabled by the wrong acknowledge polarity would drop or repeat words, or let a new word overwrite one the consumer has not yet acknowledged. Those faults show up as order or value mismatches and as changes during a stall. A wrong rail mapping in the inversion breaks the value check. A completion tree that fires early makes in_ack rise over a spacer or fall over a word.

// File: rtl/st_pkg.sv
package st_pkg;

  // rail pair codes, written as {t, f}
  localparam logic [1:0] DR_SPACER = 2'b00;
  localparam logic [1:0] DR_ZERO   = 2'b01;
  localparam logic [1:0] DR_ONE    = 2'b10;
  localparam logic [1:0] DR_BAD    = 2'b11;

  // dual-rail NOT: exchanges the two working codes, keeps spacer and illegal
  function automatic logic [1:0] dr_not(input logic [1:0] code);
    case (code)
      DR_ZERO:   return DR_ONE;
      DR_ONE:    return DR_ZERO;
      DR_SPACER: return DR_SPACER;
      DR_BAD:    return DR_BAD;
      default:   return code;
    endcase
  endfunction

endpackage

// File: rtl/st_celem.sv
// N-input Muller C-element, unit-delay model: rises when all inputs are
// high, falls when all are low, holds otherwise.
module st_celem #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] a,
  output logic         q
);

  logic q_nxt;

  always_comb begin
    q_nxt = q;
    if (&a)
      q_nxt = 1'b1;
    else if (~|a)
      q_nxt = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      q <= 1'b0;
    else
      q <= q_nxt;
  end

endmodule

// File: rtl/st_ctree.sv
// Completion tree of two- and three-input C-elements, split recursively.
module st_ctree #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] leaf,
  output logic         root
);

  generate
    if (N <= 3) begin : g_leaf
      st_celem #(.N(N)) u_node (
        .clk   (clk),
        .rst_n (rst_n),
        .a     (leaf),
        .q     (root)
      );
    end else begin : g_split
      localparam int NLO = N / 2;
      localparam int NHI = N - NLO;
      logic lo_q;
      logic hi_q;

      st_ctree #(.N(NLO)) u_lo (
        .clk   (clk),
        .rst_n (rst_n),
        .leaf  (leaf[NLO-1:0]),
        .root  (lo_q)
      );

      st_ctree #(.N(NHI)) u_hi (
        .clk   (clk),
        .rst_n (rst_n),
        .leaf  (leaf[N-1:NLO]),
        .root  (hi_q)
      );

      st_celem #(.N(2)) u_top (
        .clk   (clk),
        .rst_n (rst_n),
        .a     ({hi_q, lo_q}),
        .q     (root)
      );
    end
  endgenerate

endmodule

// File: rtl/st_stage.sv
// One pipeline stage: dual-rail inversion, C-element register, indication.
module st_stage
  import st_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] in_t,
  input  logic [W-1:0] in_f,
  input  logic         ack_next,
  output logic [W-1:0] out_t,
  output logic [W-1:0] out_f,
  output logic         ind
);

  logic [W-1:0] fn_t;
  logic [W-1:0] fn_f;
  logic [W-1:0] fn_ind;
  logic [W-1:0] rg_ind;
  logic         fn_done;
  logic         rg_done;
  logic         take_n;

  // register follows the logic only while the next stage shows spacer
  // (to take a word) or shows a completed word (to take the spacer)
  assign take_n = ~ack_next;

  genvar b;
  generate
    for (b = 0; b < W; b++) begin : g_bit
      logic [1:0] pair_out;

      assign pair_out  = dr_not({in_t[b], in_f[b]});
      assign fn_t[b]   = pair_out[1];
      assign fn_f[b]   = pair_out[0];
      assign fn_ind[b] = fn_t[b] | fn_f[b];

      st_celem #(.N(2)) u_rail_t (
        .clk   (clk),
        .rst_n (rst_n),
        .a     ({fn_t[b], take_n}),
        .q     (out_t[b])
      );

      st_celem #(.N(2)) u_rail_f (
        .clk   (clk),
        .rst_n (rst_n),
        .a     ({fn_f[b], take_n}),
        .q     (out_f[b])
      );

      assign rg_ind[b] = out_t[b] | out_f[b];
    end
  endgenerate

  // the logic's completion tree runs alongside the data wave
  st_ctree #(.N(W)) u_fn_tree (
    .clk   (clk),
    .rst_n (rst_n),
    .leaf  (fn_ind),
    .root  (fn_done)
  );

  st_ctree #(.N(W)) u_rg_tree (
    .clk   (clk),
    .rst_n (rst_n),
    .leaf  (rg_ind),
    .root  (rg_done)
  );

  st_celem #(.N(2)) u_ind (
    .clk   (clk),
    .rst_n (rst_n),
    .a     ({fn_done, rg_done}),
    .q     (ind)
  );

endmodule

// File: rtl/selftimed_pipe.sv
module selftimed_pipe #(
  parameter int W      = 8,
  parameter int STAGES = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] in_t,
  input  logic [W-1:0] in_f,
  output logic         in_ack,
  output logic [W-1:0] out_t,
  output logic [W-1:0] out_f,
  input  logic         out_ack
);

  localparam int NODES = STAGES + 1;

  logic [W-1:0] lnk_t [NODES];
  logic [W-1:0] lnk_f [NODES];
  logic         st_ind [STAGES];
  logic         st_ack [STAGES];

  assign lnk_t[0] = in_t;
  assign lnk_f[0] = in_f;

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == STAGES - 1) begin : g_last
        assign st_ack[s] = out_ack;
      end else begin : g_mid
        assign st_ack[s] = st_ind[s+1];
      end

      st_stage #(.W(W)) u_stage (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_t     (lnk_t[s]),
        .in_f     (lnk_f[s]),
        .ack_next (st_ack[s]),
        .out_t    (lnk_t[s+1]),
        .out_f    (lnk_f[s+1]),
        .ind      (st_ind[s])
      );
    end
  endgenerate

  assign in_ack = st_ind[0];
  assign out_t  = lnk_t[STAGES];
  assign out_f  = lnk_f[STAGES];

endmodule

// File: rtl/selftimed_pipe_chk.sv
module selftimed_pipe_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] in_t,
  input logic [W-1:0] in_f,
  input logic         in_ack,
  input logic [W-1:0] out_t,
  input logic [W-1:0] out_f,
  input logic         out_ack
);

  logic in_full;
  logic out_full;
  logic in_empty;

  assign in_full  = &(in_t ^ in_f);
  assign in_empty = ~|(in_t | in_f);
  assign out_full = &(out_t ^ out_f);

  // R1
  no_illegal_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_t & out_f) == '0);

  // R4
  always @(negedge clk) begin
    if (rst_n == 1'b0)
      reset_spacer_chk: assert (out_t == '0 && out_f == '0 && in_ack == 1'b0);
  end

  // R5
  ack_rise_on_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_ack) |-> in_full);

  // R5
  ack_fall_on_spacer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(in_ack) |-> in_empty);

  // R6
  hold_while_stalled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_full && !out_ack) |=> ($stable(out_t) && $stable(out_f)));

  // R7
  no_fall_before_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_ack |=> ((($past(out_t) & ~out_t) | ($past(out_f) & ~out_f)) == '0));

  // R7
  no_rise_during_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_ack |=> (((~$past(out_t) & out_t) | (~$past(out_f) & out_f)) == '0));

endmodule

module st_stage_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] out_t,
  input logic [W-1:0] out_f
);

  // R1
  no_illegal_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_t & out_f) == '0);

endmodule

bind selftimed_pipe selftimed_pipe_chk #(.W(W)) u_pipe_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .in_t    (in_t),
  .in_f    (in_f),
  .in_ack  (in_ack),
  .out_t   (out_t),
  .out_f   (out_f),
  .out_ack (out_ack)
);

bind st_stage st_stage_chk #(.W(W)) u_stage_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .out_t (out_t),
  .out_f (out_f)
);

// File: tb/selftimed_pipe_test.sv
module selftimed_pipe_test;

  localparam int W      = 8;
  localparam int STAGES = 5;
  localparam int NITEMS = 300;

  logic         clk;
  logic         rst_n;
  logic [W-1:0] in_t;
  logic [W-1:0] in_f;
  logic         in_ack;
  logic [W-1:0] out_t;
  logic [W-1:0] out_f;
  logic         out_ack;

  int checks = 0;
  int errors = 0;
  int rcvd   = 0;
  logic [W-1:0] sent [NITEMS];

  selftimed_pipe #(.W(W), .STAGES(STAGES)) uut (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_t    (in_t),
    .in_f    (in_f),
    .in_ack  (in_ack),
    .out_t   (out_t),
    .out_f   (out_f),
    .out_ack (out_ack)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [W-1:0] expect_of(input logic [W-1:0] v);
    return (STAGES % 2 == 1) ? ~v : v;
  endfunction

  function automatic logic [W-1:0] item_of(input int k);
    case (k)
      0:       return '0;
      1:       return '1;
      2:       return {(W/2){2'b01}};
      3:       return {(W/2){2'b10}};
      4:       return W'(1);
      5:       return W'(1) << (W-1);
      default: return W'($urandom);
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  // producer: four-phase with random gaps
  task automatic source();
    for (int k = 0; k < NITEMS; k++) begin
      logic [W-1:0] v;
      v = item_of(k);
      sent[k] = v;
      @(posedge clk); #1;
      in_t = v;
      in_f = ~v;
      do @(negedge clk); while (!in_ack);
      repeat ($urandom_range(0, 3)) @(negedge clk);
      @(posedge clk); #1;
      in_t = '0;
      in_f = '0;
      do @(negedge clk); while (in_ack);
      repeat ($urandom_range(0, 3)) @(negedge clk);
    end
  endtask

  // consumer: checks value and order, stalls at random
  task automatic sink();
    for (int k = 0; k < NITEMS; k++) begin
      do @(negedge clk); while (!(&(out_t ^ out_f)));
      // R2 R3: value of word k, in order
      chk(out_t == expect_of(sent[k]), "R2 R3 word value/order", 64'(out_t), 64'(expect_of(sent[k])));
      repeat ($urandom_range(0, 6)) @(negedge clk);
      @(posedge clk); #1;
      out_ack = 1'b1;
      do @(negedge clk); while ((out_t | out_f) != '0);
      repeat ($urandom_range(0, 4)) @(negedge clk);
      @(posedge clk); #1;
      out_ack = 1'b0;
      rcvd++;
    end
  endtask

  // port monitor, sampled on the falling edge
  logic [W-1:0] p_t, p_f;
  logic         p_ack, p_inack;

  always @(negedge clk) begin
    if (rst_n) begin
      // R1
      chk((out_t & out_f) == '0, "R1 illegal output code", 64'(out_t & out_f), 64'(0));
      // R5
      if (!p_inack && in_ack)
        chk(&(in_t ^ in_f), "R5 in_ack rose without full word", 64'(in_t ^ in_f), 64'({W{1'b1}}));
      if (p_inack && !in_ack)
        chk((in_t | in_f) == '0, "R5 in_ack fell without spacer", 64'(in_t | in_f), 64'(0));
      // R6
      if (!p_ack && (&(p_t ^ p_f)))
        chk(out_t == p_t && out_f == p_f, "R6 word changed during stall", 64'({out_t, out_f}), 64'({p_t, p_f}));
      // R7
      if (!p_ack)
        chk(((p_t & ~out_t) | (p_f & ~out_f)) == '0, "R7 rail fell before ack", 64'({out_t, out_f}), 64'({p_t, p_f}));
      if (p_ack)
        chk(((~p_t & out_t) | (~p_f & out_f)) == '0, "R7 rail rose during ack", 64'({out_t, out_f}), 64'({p_t, p_f}));
    end
    p_t     = out_t;
    p_f     = out_f;
    p_ack   = out_ack;
    p_inack = in_ack;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R3 watchdog: received %0d expected %0d", rcvd, NITEMS);
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    rst_n   = 1'b0;
    in_t    = '0;
    in_f    = '0;
    out_ack = 1'b0;
    repeat (2) @(negedge clk);
    // R4: a word on the input is ignored while reset holds
    in_t = 8'hA5;
    in_f = ~8'hA5;
    repeat (3) @(negedge clk);
    chk(out_t == '0 && out_f == '0, "R4 outputs spacer in reset", 64'({out_t, out_f}), 64'(0));
    chk(in_ack == 1'b0, "R4 in_ack low in reset", 64'(in_ack), 64'(0));
    in_t = '0;
    in_f = '0;
    @(posedge clk); #1;
    rst_n = 1'b1;
    fork
      source();
      sink();
    join
    repeat (40) @(negedge clk);
    // R3: nothing extra arrives and all words were delivered
    chk((out_t | out_f) == '0, "R3 no extra word", 64'({out_t, out_f}), 64'(0));
    chk(rcvd == NITEMS, "R3 word count", 64'(rcvd), 64'(NITEMS));
    summary();
    $finish;
  end

endmodule